// File: doc/BRIEF.md
# Gated Serial Heading Transmitter

This block sends two heading words, true heading and then magnetic heading, to a downstream unit as a serial bit stream. It drives three lines: a bit clock made of narrow high pulses, a message gate that frames the whole message, and a serial data line. The bit clock is divided down from a fast system clock and never stops. It keeps running while messages are being sent and while none are being sent.

Software or an upstream unit puts the two heading words on the parallel inputs and pulses a send strobe. The words are captured on the strobe. The message starts at the next bit boundary, where a bit boundary is the system cycle right after a clock pulse ends. The gate rises one bit period before the first data bit and falls one bit period after the last data bit. A strobe that arrives while a message is in flight is held and sent once the gate has dropped. If another strobe arrives before that, it replaces the held words.

With a 48 MHz system clock and the default settings, the bit period is 40 cycles (1.2 MHz) and each pulse lasts 5 cycles, which is about 104 ns.

Top module: `heading_serial_tx`

## Requirements
- R1: The bit clock repeats every DIV system cycles, with a default of 40. The time from one rising edge to the next is always exactly DIV cycles.
- R2: Each bit clock pulse is high for exactly PW consecutive system cycles, with a default of 5, and low for the rest of the period.
- R3: The bit clock runs without a break from the first cycle after reset, whether or not a message is in progress. Its first pulse starts in the first cycle after reset is released.
- R4: The message gate changes only in the cycle in which a clock pulse has just ended. A message keeps the gate high for exactly 2*HDG_W+2 pulses. In the first and last of those pulses the data line is 0, and the data bits lie between them.
- R5: The data bits go out in this order: the true heading, MSB first, then the magnetic heading, MSB first. The data bit for a pulse is the level of the data line during that pulse.
- R6: The data line changes only in the cycle in which a clock pulse has just ended. It is 0 whenever the gate is low.
- R7: The heading words are captured in the cycle in which send_i is high, and changes to the inputs after that cycle have no effect. From idle, the gate rises at the first bit boundary after the strobe cycle.
- R8: A strobe sent during a message is held. Its message starts at the first bit boundary after the gate falls, so the gate stays low for exactly DIV cycles between the two messages.
- R9: A second strobe that arrives before a held message has started replaces the held words. Only the newest words are sent.
- R10: While reset is active, the bit clock, the gate and the data line are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| true_hdg_i | input | HDG_W | True heading word |
| mag_hdg_i | input | HDG_W | Magnetic heading word |
| send_i | input | 1 | One-cycle strobe that requests a message |
| bit_clk_o | output | 1 | Free-running narrow-pulse bit clock |
| msg_gate_o | output | 1 | High around all bits of a message |
| msg_data_o | output | 1 | Serial data, valid during each pulse |

## Verification
The hardest cases to reach are the held strobe and the overwritten strobe. Both need send_i to fire while the gate is high, and the overwrite needs a second strobe before the gate has dropped. The stimulus sends one message, waits until the gate is high, and then issues a strobe. About three bit periods later it issues a second strobe with different words. The bench then checks that only the second set of words goes out, and that the gate stays low for exactly one bit period between the two messages. A behavioural reference model runs alongside on every cycle, so strobes that land near a bit boundary are also checked.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    typedef enum logic [1:0] {
        HSX_IDLE  = 2'd0,
        HSX_LEAD  = 2'd1,
        HSX_DATA  = 2'd2,
        HSX_TRAIL = 2'd3
    } hsx_phase_e;

endpackage

// File: rtl/hsx_bitclk.sv
module hsx_bitclk #(
    parameter int DIV = 40,
    parameter int PW  = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic adv_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } bck_state_t;

    bck_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.bclk = (st_d.cnt < CW'(PW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CW'(DIV - 1);
            st_q.bclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Asserted on the last high cycle; the registered logic downstream
    // updates on the edge that ends the pulse.
    assign adv_o  = (st_q.cnt == CW'(PW - 1));
    assign bclk_o = st_q.bclk;

endmodule

// File: rtl/hsx_shifter.sv
module hsx_shifter #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] load_val_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [N-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = load_val_i;
        end else if (shift_i) begin
            sr_d = {sr_q[N-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb_o = sr_q[N-1];

endmodule

// File: rtl/hsx_framer.sv
module hsx_framer
    import hsx_pkg::*;
#(
    parameter int HDG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    input  logic                 send_i,
    input  logic [HDG_W-1:0]     true_i,
    input  logic [HDG_W-1:0]     mag_i,
    output logic                 load_o,
    output logic [2*HDG_W-1:0]   load_val_o,
    output logic                 shift_o,
    output logic                 gate_o,
    output logic                 data_en_o
);
    localparam int MSG_W = 2 * HDG_W;
    localparam int BW    = $clog2(MSG_W);

    typedef struct packed {
        hsx_phase_e       phase;
        logic [BW-1:0]    bits;
        logic             pend;
        logic [MSG_W-1:0] words;
    } frm_state_t;

    frm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        if (adv_i) begin
            unique case (st_q.phase)
                HSX_IDLE: begin
                    if (st_q.pend) begin
                        st_d.phase = HSX_LEAD;
                        st_d.pend  = 1'b0;
                        load_o     = 1'b1;
                    end
                end
                HSX_LEAD: begin
                    st_d.phase = HSX_DATA;
                    st_d.bits  = '0;
                end
                HSX_DATA: begin
                    if (st_q.bits == BW'(MSG_W - 1)) begin
                        st_d.phase = HSX_TRAIL;
                    end else begin
                        st_d.bits = st_q.bits + 1'b1;
                        shift_o   = 1'b1;
                    end
                end
                HSX_TRAIL: begin
                    st_d.phase = HSX_IDLE;
                end
                default: st_d.phase = HSX_IDLE;
            endcase
        end
        // A new strobe always wins over the clearing of the held request.
        if (send_i) begin
            st_d.pend  = 1'b1;
            st_d.words = {true_i, mag_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= HSX_IDLE;
            st_q.bits  <= '0;
            st_q.pend  <= 1'b0;
            st_q.words <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_val_o = st_q.words;
    assign gate_o     = (st_q.phase != HSX_IDLE);
    assign data_en_o  = (st_q.phase == HSX_DATA);

endmodule

// File: rtl/heading_serial_tx.sv
module heading_serial_tx #(
    parameter int HDG_W = 16,
    parameter int DIV   = 40,
    parameter int PW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HDG_W-1:0] true_hdg_i,
    input  logic [HDG_W-1:0] mag_hdg_i,
    input  logic             send_i,
    output logic             bit_clk_o,
    output logic             msg_gate_o,
    output logic             msg_data_o
);
    localparam int MSG_W = 2 * HDG_W;

    logic             adv;
    logic             load;
    logic             shift;
    logic             data_en;
    logic             msb;
    logic [MSG_W-1:0] load_val;

    hsx_bitclk #(.DIV(DIV), .PW(PW)) bitclk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_o (bit_clk_o),
        .adv_o  (adv)
    );

    hsx_framer #(.HDG_W(HDG_W)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .send_i     (send_i),
        .true_i     (true_hdg_i),
        .mag_i      (mag_hdg_i),
        .load_o     (load),
        .load_val_o (load_val),
        .shift_o    (shift),
        .gate_o     (msg_gate_o),
        .data_en_o  (data_en)
    );

    hsx_shifter #(.N(MSG_W)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .shift_i    (shift),
        .msb_o      (msb)
    );

    assign msg_data_o = data_en & msb;

endmodule

// File: rtl/hsx_checks.sv
module hsx_checks #(
    parameter int HDG_W = 16,
    parameter int DIV   = 40,
    parameter int PW    = 5
) (
    input logic clk,
    input logic rst_n,
    input logic bclk,
    input logic gate,
    input logic data
);
    int  hi_run;
    int  lo_run;
    int  pulses;
    logic seen_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run    <= 0;
            lo_run    <= 0;
            pulses    <= 0;
            seen_fall <= 1'b0;
        end else begin
            hi_run    <= bclk ? hi_run + 1 : 0;
            lo_run    <= bclk ? 0 : lo_run + 1;
            seen_fall <= seen_fall | (!bclk && hi_run != 0);
            if (!gate) begin
                pulses <= 0;
            end else if (bclk && hi_run == 0) begin
                pulses <= pulses + 1;
            end
        end
    end

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk && hi_run != 0) |-> (hi_run == PW));

    assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && hi_run == 0 && seen_fall) |-> (lo_run == DIV - PW));

    assert_gate_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate) |-> $fell(bclk));

    assert_gate_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> (pulses == 2 * HDG_W + 2));

    assert_data_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data) |-> $fell(bclk));

    assert_data_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data |-> gate);

endmodule

bind heading_serial_tx hsx_checks #(.HDG_W(HDG_W), .DIV(DIV), .PW(PW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bclk  (bit_clk_o),
    .gate  (msg_gate_o),
    .data  (msg_data_o)
);

// File: tb/heading_serial_tx_tb_top.sv
module heading_serial_tx_tb_top;
    localparam int W   = 16;
    localparam int DIV = 40;
    localparam int PW  = 5;
    localparam int MSG = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         send = 1'b0;
    logic [W-1:0] th = '0;
    logic [W-1:0] mh = '0;
    logic         bclk, gate, data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    heading_serial_tx #(.HDG_W(W), .DIV(DIV), .PW(PW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .true_hdg_i (th),
        .mag_hdg_i  (mh),
        .send_i     (send),
        .bit_clk_o  (bclk),
        .msg_gate_o (gate),
        .msg_data_o (data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge.
    int       m_cnt = DIV - 1;
    int       m_st = 0;          // 0 idle, 1 lead, 2 data, 3 trail
    bit       m_pend = 0;
    bit [MSG-1:0] m_buf = '0;
    bit       m_q[$];
    bit       m_bclk = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = DIV - 1; m_st = 0; m_pend = 0; m_buf = '0; m_bclk = 0;
            m_q.delete();
        end else begin
            if (m_cnt == PW - 1) begin
                case (m_st)
                    0: if (m_pend) begin
                        m_st = 1; m_pend = 0; m_q.delete();
                        for (int i = MSG - 1; i >= 0; i--) m_q.push_back(m_buf[i]);
                    end
                    1: m_st = 2;
                    2: begin
                        void'(m_q.pop_front());
                        if (m_q.size() == 0) m_st = 3;
                    end
                    default: m_st = 0;
                endcase
            end
            if (send) begin
                m_pend = 1;
                m_buf  = {th, mh};
            end
            m_cnt  = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            m_bclk = (m_cnt < PW);
        end
    end

    // Monitor: per-cycle comparison and stream decode.
    int       cyc = 0;
    int       rises = 0;
    int       last_rise = -1;
    int       hi = 0;
    int       fall_cyc = -1;
    bit       p_bclk = 0, p_gate = 0, p_data = 0;
    bit       fr[$];
    logic [MSG-1:0] msgs[$];
    int       lens[$];
    bit       ends_ok[$];
    int       gaps[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(bclk == 1'b0 && gate == 1'b0 && data == 1'b0, "R10 reset outputs",
                {bclk, gate, data}, 0);
        end else begin
            chk(bclk == m_bclk, "R1 bit clock vs model", bclk, m_bclk);
            chk(gate == (m_st != 0), "R4 R7 gate vs model", gate, m_st != 0);
            chk(data == ((m_st == 2) ? m_q[0] : 1'b0), "R5 data vs model", data,
                (m_st == 2) ? m_q[0] : 1'b0);
            if (bclk && !p_bclk) begin
                if (last_rise >= 0) chk(cyc - last_rise == DIV, "R1 period", cyc - last_rise, DIV);
                last_rise = cyc;
                rises++;
                if (gate) fr.push_back(data);
            end
            if (!bclk && p_bclk) chk(hi == PW, "R2 pulse width", hi, PW);
            hi = bclk ? hi + 1 : 0;
            if (data != p_data) chk(p_bclk && !bclk, "R6 data change point", bclk, 0);
            if (data) chk(gate, "R6 data outside gate", gate, 1);
            if (gate && !p_gate && fall_cyc >= 0) gaps.push_back(cyc - fall_cyc);
            if (!gate && p_gate) begin
                logic [MSG-1:0] w;
                w = '0;
                fall_cyc = cyc;
                lens.push_back(fr.size());
                if (fr.size() == MSG + 2) begin
                    for (int i = 0; i < MSG; i++) w[MSG-1-i] = fr[i+1];
                    ends_ok.push_back(fr[0] == 0 && fr[MSG+1] == 0);
                end else begin
                    ends_ok.push_back(1'b0);
                end
                msgs.push_back(w);
                fr.delete();
            end
            p_bclk = bclk; p_gate = gate; p_data = data;
            cyc++;
        end
    end

    task automatic strobe(input logic [W-1:0] t, input logic [W-1:0] m);
        @(negedge clk);
        th = t; mh = m; send = 1'b1;
        @(negedge clk);
        send = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3 * DIV) @(negedge clk);

        // R7: words captured at strobe; later input change ignored
        strobe(16'hA5C3, 16'h1234);
        th = 16'hFFFF; mh = 16'h0000;
        wait (gate == 1'b1);
        wait (gate == 1'b0);
        repeat (2 * DIV) @(negedge clk);

        // R8, R9: strobes during a message, second one replaces the first
        strobe(16'h0001, 16'h8000);
        wait (gate == 1'b1);
        repeat (5 * DIV) @(negedge clk);
        strobe(16'h7E7E, 16'h00FF);
        repeat (3 * DIV + 7) @(negedge clk);
        strobe(16'hFFFF, 16'h0F0F);
        wait (gate == 1'b0);
        wait (gate == 1'b1);
        wait (gate == 1'b0);
        repeat (3 * DIV) @(negedge clk);

        chk(msgs.size() == 3, "R9 message count", msgs.size(), 3);
        for (int i = 0; i < lens.size(); i++) begin
            chk(lens[i] == MSG + 2, "R4 pulses under gate", lens[i], MSG + 2);
            chk(ends_ok[i], "R4 lead and trail bits zero", ends_ok[i], 1);
        end
        if (msgs.size() == 3) begin
            chk(msgs[0] == 32'hA5C3_1234, "R7 R5 first message", msgs[0], 32'hA5C3_1234);
            chk(msgs[1] == 32'h0001_8000, "R5 second message", msgs[1], 32'h0001_8000);
            chk(msgs[2] == 32'hFFFF_0F0F, "R9 overwritten message", msgs[2], 32'hFFFF_0F0F);
        end
        chk(gaps.size() == 2, "R8 gap count", gaps.size(), 2);
        if (gaps.size() == 2) chk(gaps[1] == DIV, "R8 gate low between messages", gaps[1], DIV);
        chk(rises == (cyc - 1) / DIV + 1, "R3 continuous pulses", rises, (cyc - 1) / DIV + 1);
        finish_run();
    end

endmodule